// File: doc/BRIEF.md
# Four-Operator FM Envelope Generator

This block produces the attenuation envelopes for the four operators of one FM synthesis voice. Each operator moves through attack, decay, sustain and release phases and then goes silent. It holds a 10-bit attenuation (0 is loudest, 1023 is silent) and a phase. The host feeds one step value per audio sample. A fractional timer turns these steps into envelope ticks, one tick each time the accumulated time crosses three sample periods. Each tick advances a shared envelope counter and updates every operator whose rate allows a change on that counter value.

Every phase has its own packed rate word. The top byte is a counter shift S. The low 24 bits hold eight 3-bit increment selectors, and the counter picks one of them in turn, which gives fine rate steps without a divider. Attack is exponential: the step is taken from the complement of the attenuation. The other phases add a linear step. Rates, sustain level and total level are written per operator through a small configuration port. Key-on and key-off pulses start and stop notes.

The sample input is a valid/ready stream. A sample is accepted on a cycle where both `sample_valid` and `sample_ready` are high. `sample_ready` is low while ticks are still pending, and the block processes one tick per clock until the timer drops below three sample periods. A producer that holds `sample_valid` high simply waits. No step is lost or counted twice.

Top module: `fm_env_gen`

## Requirements
- R1: After reset every operator is silent with attenuation 1023. Each `env_out` field reads 1023, `eg_cnt` reads 0, and `sample_ready` is high.
- R2: An accepted sample adds `sample_step` (16 fractional bits) to a timer. While the timer is at or above 3<<16, the block spends one cycle per tick with `sample_ready` low. Each tick subtracts 3<<16 from the timer and increments `eg_cnt` by one, wrapping at its width.
- R3: The rate word of the current phase carries a shift S in bits 31:24. An operator changes on a tick only when the low S bits of the new counter value are all zero. It then uses selector k = bits [3i+2:3i], where i = (counter >> S) & 7.
- R4: A `key_on` bit puts its operator into attack and leaves the attenuation unchanged. A `key_off` bit puts any operator that is not silent into release. If both bits are set for one operator, `key_on` wins. A key event replaces any tick update of that operator in the same cycle.
- R5: In attack, the attenuation grows by floor(-(att+1)·2^k / 32), which is never positive. A result of zero or below sets the attenuation to 0 and enters decay.
- R6: In decay, the attenuation grows by (1<<k)>>1, saturating at 1023. Decay enters sustain once the attenuation is at or above the sustain level.
- R7: In sustain, the attenuation grows by (1<<k)>>1 and is clamped at 1023.
- R8: In release, the attenuation grows by (1<<k)>>1 and is clamped at 1023. On reaching 1023 the operator becomes silent.
- R9: A silent operator never changes. Its output holds and `key_off` has no effect on it.
- R10: Field o of `env_out` (bits [11o+10:11o], operator o = 0..3) is the 11-bit sum of that operator's attenuation and total level. It is refreshed only on a tick that updates the operator, so writing a new total level alone leaves it unchanged.
- R11: A configuration write targets operator `cfg_op`. `cfg_sel` selects the field: 0 = attack rate, 1 = decay rate, 2 = sustain rate, 3 = release rate, 4 = sustain level (`cfg_wdata[9:0]`), 5 = total level (`cfg_wdata[9:0]`). Codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | A sample step is offered |
| sample_step | input | STEP_W | Timer increment, 16 fractional bits |
| sample_ready | output | 1 | No tick pending; a step can be taken |
| key_on | input | NUM_OPS | Per-operator key-on pulse |
| key_off | input | NUM_OPS | Per-operator key-off pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | OP_W | Target operator |
| cfg_sel | input | 3 | Target field code |
| cfg_wdata | input | 32 | Write data |
| env_out | output | NUM_OPS*11 | Per-operator attenuation plus total level |
| eg_cnt | output | CNT_W | Global envelope counter |

## Verification
The hardest situation to reach is an operator whose selector pattern, shift and phase all line up so that the counter gating, the exponential attack arithmetic and a phase change meet on the same tick. A release that reaches the ceiling right after a key-off from decay is one example. Plain stimulus rarely lines these up. The bench therefore sweeps many configurations that are derived arithmetically and differ per operator. It combines them with four step sizes, including fractional steps that give zero ticks per sample and large steps that give three. It then runs key-on, partial key-off, re-trigger and full release phases long enough for operators to finish attack and fall silent.

// File: rtl/fm_env_pkg.sv
package fm_env_pkg;
  parameter int ATT_W = 10;
  localparam logic [ATT_W-1:0] ATT_MAX = '1;

  typedef enum logic [2:0] {
    PH_OFF = 3'd0,
    PH_REL = 3'd1,
    PH_SUS = 3'd2,
    PH_DEC = 3'd3,
    PH_ATK = 3'd4
  } phase_e;

  localparam logic [2:0] SEL_AR = 3'd0;
  localparam logic [2:0] SEL_DR = 3'd1;
  localparam logic [2:0] SEL_SR = 3'd2;
  localparam logic [2:0] SEL_RR = 3'd3;
  localparam logic [2:0] SEL_SL = 3'd4;
  localparam logic [2:0] SEL_TL = 3'd5;
endpackage

// File: rtl/fm_env_timer.sv
module fm_env_timer #(
  parameter int STEP_W = 20,
  parameter int FRAC   = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [STEP_W-1:0] sample_step,
  output logic              sample_ready,
  output logic              tick,
  output logic [CNT_W-1:0]  cnt_next,
  output logic [CNT_W-1:0]  eg_cnt
);
  localparam int BASE_W = (STEP_W > FRAC + 2) ? STEP_W : FRAC + 2;
  localparam int TMR_W  = BASE_W + 1;
  localparam logic [TMR_W-1:0] OVF = TMR_W'(3) << FRAC;

  logic [TMR_W-1:0] timer_q;
  logic [CNT_W-1:0] cnt_q;

  assign tick         = (timer_q >= OVF);
  assign sample_ready = ~tick;
  assign cnt_next     = cnt_q + CNT_W'(1);
  assign eg_cnt       = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= '0;
      cnt_q   <= '0;
    end else if (tick) begin
      timer_q <= timer_q - OVF;
      cnt_q   <= cnt_next;
    end else if (sample_valid) begin
      timer_q <= timer_q + TMR_W'(sample_step);
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_ready |=> eg_cnt == $past(eg_cnt) + CNT_W'(1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_ready |=> $stable(eg_cnt));
  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ready && sample_valid) |=> timer_q == $past(timer_q) + TMR_W'($past(sample_step)));
endmodule

// File: rtl/fm_env_op.sv
module fm_env_op
  import fm_env_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic             key_on,
  input  logic             key_off,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [ATT_W:0]   env_out
);
  logic [31:0]      rate_q [4];
  logic [ATT_W-1:0] sl_q, tl_q, att_q, att_n;
  phase_e           ph_q, ph_n;
  logic [ATT_W:0]   out_q;

  logic [31:0]      rate;
  logic [7:0]       sh;
  logic [CNT_W-1:0] low_mask;
  logic [2:0]       idx, k;
  logic             gate, key_evt, upd;
  logic signed [19:0] neg_att, inc_a, sum_a;
  logic [7:0]       lin_step;
  logic [ATT_W:0]   sum_l;
  logic [ATT_W-1:0] sat_l;

  always_comb begin
    case (ph_q)
      PH_ATK:  rate = rate_q[0];
      PH_DEC:  rate = rate_q[1];
      PH_SUS:  rate = rate_q[2];
      PH_REL:  rate = rate_q[3];
      default: rate = '0;
    endcase
  end

  assign sh       = rate[31:24];
  assign low_mask = (32'(sh) >= 32'(CNT_W)) ? '1 : ((CNT_W'(1) << sh) - CNT_W'(1));
  assign gate     = ((cnt & low_mask) == '0);
  assign idx      = (32'(sh) >= 32'(CNT_W)) ? 3'd0 : 3'(cnt >> sh);
  assign k        = 3'(rate >> (5'(idx) * 5'd3));
  assign key_evt  = key_on | (key_off & (ph_q != PH_OFF));
  assign upd      = tick & (ph_q != PH_OFF) & gate & ~key_evt;

  assign neg_att  = -$signed({10'd0, att_q}) - 20'sd1;
  assign inc_a    = (neg_att <<< k) >>> 5;
  assign sum_a    = $signed({10'd0, att_q}) + inc_a;
  assign lin_step = 8'((9'd1 << k) >> 1);
  assign sum_l    = {1'b0, att_q} + (ATT_W + 1)'(lin_step);
  assign sat_l    = (sum_l >= (ATT_W + 1)'(ATT_MAX)) ? ATT_MAX : sum_l[ATT_W-1:0];

  always_comb begin
    att_n = att_q;
    ph_n  = ph_q;
    case (ph_q)
      PH_ATK: begin
        if (sum_a <= 20'sd0) begin
          att_n = '0;
          ph_n  = PH_DEC;
        end else begin
          att_n = sum_a[ATT_W-1:0];
        end
      end
      PH_DEC: begin
        att_n = sat_l;
        if (sat_l >= sl_q) ph_n = PH_SUS;
      end
      PH_SUS: att_n = sat_l;
      PH_REL: begin
        att_n = sat_l;
        if (sat_l == ATT_MAX) ph_n = PH_OFF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) rate_q[i] <= '0;
      sl_q <= '0;
      tl_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_AR, SEL_DR, SEL_SR, SEL_RR: rate_q[cfg_sel[1:0]] <= cfg_wdata;
        SEL_SL: sl_q <= cfg_wdata[ATT_W-1:0];
        SEL_TL: tl_q <= cfg_wdata[ATT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_OFF;
      att_q <= ATT_MAX;
      out_q <= (ATT_W + 1)'(ATT_MAX);
    end else if (key_on) begin
      ph_q <= PH_ATK;
    end else if (key_off && ph_q != PH_OFF) begin
      ph_q <= PH_REL;
    end else if (upd) begin
      ph_q  <= ph_n;
      att_q <= att_n;
      out_q <= {1'b0, att_n} + {1'b0, tl_q};
    end
  end

  assign env_out = out_q;

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_OFF && !key_on) |=> ($stable(att_q) && ph_q == PH_OFF));
  // R8
  rel_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_REL && ph_q == PH_OFF) |-> att_q == ATT_MAX);
  // R5
  atk_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ph_q) == PH_ATK && ph_q == PH_DEC) |-> att_q == '0);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(env_out));
  // R4
  key_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_on |=> (ph_q == PH_ATK && $stable(att_q)));
endmodule

// File: rtl/fm_env_gen.sv
module fm_env_gen
  import fm_env_pkg::*;
#(
  parameter int NUM_OPS = 4,
  parameter int STEP_W  = 20,
  parameter int FRAC    = 16,
  parameter int CNT_W   = 16,
  localparam int OP_W   = (NUM_OPS > 1) ? $clog2(NUM_OPS) : 1,
  localparam int OUT_W  = ATT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_valid,
  input  logic [STEP_W-1:0]        sample_step,
  output logic                     sample_ready,
  input  logic [NUM_OPS-1:0]       key_on,
  input  logic [NUM_OPS-1:0]       key_off,
  input  logic                     cfg_we,
  input  logic [OP_W-1:0]          cfg_op,
  input  logic [2:0]               cfg_sel,
  input  logic [31:0]              cfg_wdata,
  output logic [NUM_OPS*OUT_W-1:0] env_out,
  output logic [CNT_W-1:0]         eg_cnt
);
  logic             tick;
  logic [CNT_W-1:0] cnt_next;

  fm_env_timer #(.STEP_W(STEP_W), .FRAC(FRAC), .CNT_W(CNT_W)) u_timer (
    .clk, .rst_n, .sample_valid, .sample_step, .sample_ready,
    .tick, .cnt_next, .eg_cnt
  );

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic op_we;
    assign op_we = cfg_we && (32'(cfg_op) == g);
    fm_env_op #(.CNT_W(CNT_W)) u_op (
      .clk, .rst_n, .tick, .cnt(cnt_next),
      .key_on(key_on[g]), .key_off(key_off[g]),
      .cfg_we(op_we), .cfg_sel, .cfg_wdata,
      .env_out(env_out[g*OUT_W +: OUT_W])
    );
  end
endmodule

// File: tb/fm_env_gen_tb.sv
module fm_env_gen_tb;
  localparam int NOPS = 4;
  localparam int OVF  = 3 << 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        sample_valid = 0;
  logic [19:0] sample_step = '0;
  logic        sample_ready;
  logic [3:0]  key_on = '0, key_off = '0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_op = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [43:0] env_out;
  logic [15:0] eg_cnt;

  fm_env_gen u_dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  int m_att[NOPS], m_ph[NOPS], m_out[NOPS], m_sl[NOPS], m_tl[NOPS];
  int m_rate[NOPS][4];
  int m_cnt = 0, m_tmr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string ph_tag(input int p);
    case (p)
      4: return "R3 R5 attack";
      3: return "R3 R6 decay";
      2: return "R3 R7 sustain";
      1: return "R3 R8 release";
      default: return "R9 silent";
    endcase
  endfunction

  function automatic void model_tick(input int c);
    for (int o = 0; o < NOPS; o++) begin
      int r, s, i, k, a;
      if (m_ph[o] == 0) continue;
      r = m_rate[o][4 - m_ph[o]];
      s = (r >> 24) & 255;
      if ((c & ((1 << s) - 1)) != 0) continue;
      i = (c >> s) & 7;
      k = (r >> (3 * i)) & 7;
      if (m_ph[o] == 4) begin
        int v;
        v = -(m_att[o] + 1);
        v = v <<< k;
        v = v >>> 5;
        a = m_att[o] + v;
        if (a <= 0) begin a = 0; m_ph[o] = 3; end
      end else begin
        a = m_att[o] + ((1 << k) >> 1);
        if (a > 1023) a = 1023;
        if (m_ph[o] == 3 && a >= m_sl[o]) m_ph[o] = 2;
        else if (m_ph[o] == 1 && a >= 1023) m_ph[o] = 0;
      end
      m_att[o] = a;
      m_out[o] = a + m_tl[o];
    end
  endfunction

  task automatic cmp_outs(input string pre, input int ph0 [NOPS]);
    for (int o = 0; o < NOPS; o++) begin
      int act;
      act = int'(env_out[o*11 +: 11]);
      chk(act == m_out[o], $sformatf("%s %s op%0d R10", pre, ph_tag(ph0[o]), o), act, m_out[o]);
    end
  endtask

  task automatic do_sample(input int step, input string pre);
    int n, exp_n, ph0 [NOPS];
    for (int o = 0; o < NOPS; o++) ph0[o] = m_ph[o];
    @(negedge clk);
    sample_valid = 1; sample_step = 20'(step);
    @(negedge clk);
    sample_valid = 0;
    n = 0;
    while (!sample_ready) begin n++; @(negedge clk); end
    m_tmr += step; exp_n = 0;
    while (m_tmr >= OVF) begin
      m_tmr -= OVF; m_cnt = (m_cnt + 1) & 16'hFFFF; exp_n++;
      model_tick(m_cnt);
    end
    chk(n == exp_n, "R2 tick cycles", n, exp_n);
    chk(int'(eg_cnt) == m_cnt, "R2 counter", int'(eg_cnt), m_cnt);
    cmp_outs(pre, ph0);
  endtask

  task automatic cfg_write(input int op, input int sel, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_op = 2'(op); cfg_sel = 3'(sel); cfg_wdata = 32'(data);
    @(negedge clk);
    cfg_we = 0;
    if (sel < 4) m_rate[op][sel] = data;
    else if (sel == 4) m_sl[op] = data & 1023;
    else if (sel == 5) m_tl[op] = data & 1023;
  endtask

  task automatic keys(input logic [3:0] on, input logic [3:0] off);
    @(negedge clk);
    key_on = on; key_off = off;
    @(negedge clk);
    key_on = '0; key_off = '0;
    for (int o = 0; o < NOPS; o++) begin
      if (on[o]) m_ph[o] = 4;
      else if (off[o] && m_ph[o] != 0) m_ph[o] = 1;
    end
  endtask

  function automatic int mk_rate(input int s, input int seed, input bit fast);
    int r;
    r = s << 24;
    for (int i = 0; i < 8; i++) begin
      int sel;
      sel = (seed * 3 + i * 5 + (seed >> 2) + i * i) % 8;
      if (fast) sel = (sel % 4) + 4;
      r |= sel << (3 * i);
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int steps[4];
    int ph0 [NOPS];
    steps[0] = 3 << 16; steps[1] = 1 << 16; steps[2] = 'h2C000; steps[3] = 'h90000;
    for (int o = 0; o < NOPS; o++) begin
      m_att[o] = 1023; m_ph[o] = 0; m_out[o] = 1023; m_sl[o] = 0; m_tl[o] = 0;
      for (int j = 0; j < 4; j++) m_rate[o][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    for (int o = 0; o < NOPS; o++)
      chk(int'(env_out[o*11 +: 11]) == 1023, "R1 reset output", int'(env_out[o*11 +: 11]), 1023);
    chk(int'(eg_cnt) == 0, "R1 reset counter", int'(eg_cnt), 0);
    chk(sample_ready == 1'b1, "R1 reset ready", int'(sample_ready), 1);

    // R9 silent operators and key_off on silent ones
    keys(4'b0000, 4'b1111);
    for (int j = 0; j < 5; j++) do_sample(3 << 16, "R9 idle");

    for (int c = 0; c < 24; c++) begin
      for (int o = 0; o < NOPS; o++) begin
        int s;
        s = (c + o) % 3;
        cfg_write(o, 0, mk_rate(s, c * 4 + o, (c % 3) != 0));
        cfg_write(o, 1, mk_rate((s + 1) % 3, c * 5 + o + 1, 0));
        cfg_write(o, 2, mk_rate(s, c * 7 + o + 2, 0));
        cfg_write(o, 3, mk_rate((s + 2) % 3, c * 3 + o + 3, (c % 2) == 0));
        cfg_write(o, 4, (c * 97 + o * 211) % 1024);
        cfg_write(o, 5, (c * 13 + o * 29) % 1024);
      end
      // R4 key-on from any phase, with key_on winning over key_off on op 3
      keys(4'b1111, 4'b1000);
      for (int j = 0; j < 120; j++) do_sample(steps[c % 4], "main");
      keys(4'b0000, 4'b0101);
      for (int j = 0; j < 60; j++) do_sample(steps[(c + 1) % 4], "partial off");
      // R10 total level write alone leaves output unchanged
      cfg_write(1, 5, (c * 31 + 7) % 1024);
      for (int o = 0; o < NOPS; o++) ph0[o] = m_ph[o];
      for (int o = 0; o < NOPS; o++)
        chk(int'(env_out[o*11 +: 11]) == m_out[o], "R10 tl write no refresh",
            int'(env_out[o*11 +: 11]), m_out[o]);
      // R11 unused field codes change nothing
      cfg_write(c % 4, 6 + (c % 2), 32'h0);
      do_sample(steps[c % 4], "R11 unused code");
      keys(4'b0100, 4'b0000);
      for (int j = 0; j < 60; j++) do_sample(steps[(c + 2) % 4], "retrigger");
      keys(4'b0000, 4'b1111);
      for (int j = 0; j < 120; j++) do_sample(steps[(c + 3) % 4], "release");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule